// File: doc/BRIEF.md
# Compare-Flag Unit

This block evaluates a relation between two operands and records the outcome in a single compare flag. The flag is later consumed by conditional branches and conditional moves elsewhere in the pipeline. Each request carries a 5-bit condition code, which selects one of ten relations. The request also says whether the second operand is a full register value or a 16-bit immediate.

The ten relations are equality, inequality, and greater / greater-or-equal / less / less-or-equal. The ordered relations come in both unsigned and two's-complement signed forms. The immediate is sign-extended before use for every relation, the unsigned ones included. Condition codes outside the defined set do not change the flag; they raise a one-cycle illegal-condition pulse instead.

All outputs are registered. A request presented with its valid strobe high shows its effect in the cycle after the next rising clock edge.

Top module: `cmpflag_unit`

## Requirements
- R1: While reset is high and in the cycle after reset is released, `flag_q`, `flag_we` and `cond_illegal` are all 0.
- R2: Code 5'h00 sets the flag when the operands are equal, and code 5'h01 sets it when they differ.
- R3: Codes 5'h02, 5'h03, 5'h04 and 5'h05 compute unsigned A>B, A>=B, A<B and A<=B respectively.
- R4: Codes 5'h0A, 5'h0B, 5'h0C and 5'h0D compute signed A>B, A>=B, A<B and A<=B respectively.
- R5: When `use_imm` is 1, the second operand is `imm` sign-extended to the data width, for every condition including the unsigned ones.
- R6: When `use_imm` is 0, the second operand is `opb`, and the value on `imm` has no effect on the result.
- R7: A legal request with `in_valid` high updates `flag_q` at the next rising edge and raises `flag_we` for exactly that one following cycle.
- R8: Without a valid request, `flag_q` keeps its value and `flag_we` stays 0, whatever the operand and code inputs carry.
- R9: A valid request with any other code (5'h06-5'h09, 5'h0E-5'h1F) gives a one-cycle `cond_illegal` pulse. In that case `flag_we` stays 0 and `flag_q` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Compare request strobe |
| cond_code | input | 5 | Relation selector |
| use_imm | input | 1 | 1 selects the sign-extended immediate as operand B |
| opa | input | 32 | Operand A |
| opb | input | 32 | Register operand B |
| imm | input | 16 | Immediate operand |
| flag_we | output | 1 | One-cycle pulse when the flag was written |
| flag_q | output | 1 | Current compare flag |
| cond_illegal | output | 1 | One-cycle pulse for an undefined condition code |

## Verification
The bench builds the unit with its default sizes: a 32-bit data path, a 16-bit immediate and a 5-bit condition field. With these sizes the sign bit sits at bit 31, so operand pairs such as 1 against 32'hFFFFFFFF separate the signed and unsigned orderings. The 16-bit immediate is narrower than the data path, so immediates with bit 15 set (16'h8000, 16'hFFFF) show whether sign extension or zero extension took place. The 5-bit field lets the bench reach every undefined code, including those with bit 4 set.

// File: rtl/cmpflag_pkg.sv
package cmpflag_pkg;

  typedef enum logic [2:0] {
    REL_EQ = 3'd0,
    REL_NE = 3'd1,
    REL_GT = 3'd2,
    REL_GE = 3'd3,
    REL_LT = 3'd4,
    REL_LE = 3'd5
  } rel_e;

  typedef struct packed {
    logic legal;
    logic is_signed;
    rel_e rel;
  } cond_dec_t;

endpackage

// File: rtl/cmpflag_decode.sv
module cmpflag_decode #(
  parameter int COND_W = 5
) (
  input  logic [COND_W-1:0]    code,
  output cmpflag_pkg::cond_dec_t dec
);
  import cmpflag_pkg::*;

  // Low three bits name the relation; bit 3 picks signed ordering.
  // Signed forms exist only for the ordered relations (low bits 2..5).
  logic [2:0] low;
  logic       sgn;
  logic       upper_zero;

  assign low = code[2:0];
  assign sgn = code[3];

  generate
    if (COND_W > 4) begin : g_upper
      assign upper_zero = (code[COND_W-1:4] == '0);
    end else begin : g_no_upper
      assign upper_zero = 1'b1;
    end
  endgenerate

  always_comb begin
    dec.is_signed = sgn;
    dec.rel       = rel_e'(low);
    dec.legal     = upper_zero && (low <= 3'd5) && (!sgn || low >= 3'd2);
    if (!dec.legal) dec.rel = REL_EQ;
  end

endmodule

// File: rtl/cmpflag_core.sv
module cmpflag_core #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              use_imm,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b_reg,
  input  logic [IMM_W-1:0]  imm,
  input  logic              is_signed,
  input  cmpflag_pkg::rel_e rel,
  output logic              result
);
  import cmpflag_pkg::*;

  logic [DATA_W-1:0] b_imm;
  logic [DATA_W-1:0] b;
  logic [DATA_W-1:0] a_bias;
  logic [DATA_W-1:0] b_bias;
  logic              eq;
  logic              lt;

  // Immediate widened with its own sign bit for every relation.
  generate
    if (DATA_W > IMM_W) begin : g_sext
      assign b_imm = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
    end else begin : g_trunc
      assign b_imm = imm[DATA_W-1:0];
    end
  endgenerate

  assign b = use_imm ? b_imm : b_reg;

  // Flipping the sign bit turns a signed order into an unsigned one,
  // so one magnitude comparator serves both flavours.
  assign a_bias = {a[DATA_W-1] ^ is_signed, a[DATA_W-2:0]};
  assign b_bias = {b[DATA_W-1] ^ is_signed, b[DATA_W-2:0]};

  assign eq = (a == b);
  assign lt = (a_bias < b_bias);

  always_comb begin
    unique case (rel)
      REL_EQ:  result = eq;
      REL_NE:  result = !eq;
      REL_GT:  result = !lt && !eq;
      REL_GE:  result = !lt;
      REL_LT:  result = lt;
      REL_LE:  result = lt || eq;
      default: result = 1'b0;
    endcase
  end

endmodule

// File: rtl/cmpflag_unit.sv
module cmpflag_unit #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int COND_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [COND_W-1:0] cond_code,
  input  logic              use_imm,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [IMM_W-1:0]  imm,
  output logic              flag_we,
  output logic              flag_q,
  output logic              cond_illegal
);
  import cmpflag_pkg::*;

  cond_dec_t dec;
  logic      cmp_res;
  logic      armed;

  cmpflag_decode #(.COND_W(COND_W)) u_dec (
    .code (cond_code),
    .dec  (dec)
  );

  cmpflag_core #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_core (
    .use_imm   (use_imm),
    .a         (opa),
    .b_reg     (opb),
    .imm       (imm),
    .is_signed (dec.is_signed),
    .rel       (dec.rel),
    .result    (cmp_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q       <= 1'b0;
      flag_we      <= 1'b0;
      cond_illegal <= 1'b0;
      armed        <= 1'b0;
    end else begin
      armed        <= 1'b1;
      flag_we      <= in_valid && dec.legal;
      cond_illegal <= in_valid && !dec.legal;
      if (in_valid && dec.legal) flag_q <= cmp_res;
    end
  end

  // R1: outputs are cleared one cycle after reset is seen
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!flag_q && !flag_we && !cond_illegal));

  // R7: a request with a legal code produces a write pulse next cycle
  a_r7_we_follows_valid: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec.legal) |=> flag_we);

  // R8: without a write pulse the flag is unchanged
  a_r8_flag_hold: assert property (@(posedge clk) disable iff (rst)
    (armed && !flag_we) |-> (flag_q == $past(flag_q)));

  // R9: illegal pulse and write pulse never coincide
  a_r9_no_write_on_illegal: assert property (@(posedge clk) disable iff (rst)
    $onehot0({flag_we, cond_illegal}));

  // R9: an undefined code never produces a write
  a_r9_illegal_blocks_we: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !dec.legal) |=> (cond_illegal && !flag_we));

endmodule

// File: tb/cmpflag_unit_tb.sv
`timescale 1ns/1ps
module cmpflag_unit_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [4:0]  cond_code;
  logic        use_imm;
  logic [31:0] opa;
  logic [31:0] opb;
  logic [15:0] imm;
  logic        flag_we;
  logic        flag_q;
  logic        cond_illegal;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  cmpflag_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .cond_code(cond_code),
    .use_imm(use_imm), .opa(opa), .opb(opb), .imm(imm),
    .flag_we(flag_we), .flag_q(flag_q), .cond_illegal(cond_illegal)
  );

  task automatic check(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  function automatic logic ref_rel(input logic [4:0] c, input logic [31:0] a,
                                   input logic [31:0] b);
    case (c)
      5'h00: return a == b;
      5'h01: return a != b;
      5'h02: return a >  b;
      5'h03: return a >= b;
      5'h04: return a <  b;
      5'h05: return a <= b;
      5'h0A: return $signed(a) >  $signed(b);
      5'h0B: return $signed(a) >= $signed(b);
      5'h0C: return $signed(a) <  $signed(b);
      5'h0D: return $signed(a) <= $signed(b);
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input logic [4:0] c);
    if (c <= 5'h01) return "R2";
    if (c <= 5'h05) return "R3";
    return "R4";
  endfunction

  // Drive one request after a falling edge, sample after the next falling edge.
  task automatic issue(input logic [4:0] c, input logic ui, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] im);
    cond_code = c; use_imm = ui; opa = a; opb = b; imm = im; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic cmp_expect(input string req, input logic [4:0] c, input logic ui,
                            input logic [31:0] a, input logic [31:0] b,
                            input logic [15:0] im, input logic exp);
    issue(c, ui, a, b, im);
    check(req, flag_q, exp);
    check(req, flag_we, 1'b1);
  endtask

  task automatic t_reset;
    rst = 1'b1; in_valid = 1'b0; cond_code = '0; use_imm = 1'b0;
    opa = '0; opb = '0; imm = '0;
    repeat (3) @(negedge clk);
    check("R1", flag_q, 1'b0);
    check("R1", flag_we, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", flag_q, 1'b0);
    check("R1", flag_we, 1'b0);
    check("R1", cond_illegal, 1'b0);
  endtask

  task automatic t_equality;
    cmp_expect("R2", 5'h00, 0, 32'd5, 32'd5, 16'h0, 1'b1);
    cmp_expect("R2", 5'h01, 0, 32'd5, 32'd5, 16'h0, 1'b0);
    cmp_expect("R2", 5'h00, 0, 32'd5, 32'd6, 16'h0, 1'b0);
    cmp_expect("R2", 5'h01, 0, 32'd5, 32'd6, 16'h0, 1'b1);
  endtask

  task automatic t_unsigned;
    cmp_expect("R3", 5'h02, 0, 32'd1, 32'hFFFFFFFF, 16'h0, 1'b0);
    cmp_expect("R3", 5'h04, 0, 32'd1, 32'hFFFFFFFF, 16'h0, 1'b1);
    cmp_expect("R3", 5'h03, 0, 32'd9, 32'd9, 16'h0, 1'b1);
    cmp_expect("R3", 5'h05, 0, 32'd9, 32'd9, 16'h0, 1'b1);
    cmp_expect("R3", 5'h02, 0, 32'd9, 32'd9, 16'h0, 1'b0);
    cmp_expect("R3", 5'h04, 0, 32'd9, 32'd9, 16'h0, 1'b0);
  endtask

  task automatic t_signed;
    cmp_expect("R4", 5'h0A, 0, 32'd1, 32'hFFFFFFFF, 16'h0, 1'b1);
    cmp_expect("R4", 5'h0C, 0, 32'd1, 32'hFFFFFFFF, 16'h0, 1'b0);
    cmp_expect("R4", 5'h0B, 0, 32'h80000000, 32'h80000000, 16'h0, 1'b1);
    cmp_expect("R4", 5'h0D, 0, 32'h80000000, 32'h7FFFFFFF, 16'h0, 1'b1);
    cmp_expect("R4", 5'h0A, 0, 32'h80000000, 32'h7FFFFFFF, 16'h0, 1'b0);
  endtask

  task automatic t_sweep;
    logic [31:0] av [6] = '{32'd0, 32'd7, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 32'h00012345};
    logic [31:0] bv [6] = '{32'd0, 32'hFFFFFFF9, 32'h80000000, 32'h7FFFFFFF, 32'd1, 32'h00012345};
    logic [4:0]  codes [10] = '{5'h00, 5'h01, 5'h02, 5'h03, 5'h04, 5'h05,
                                5'h0A, 5'h0B, 5'h0C, 5'h0D};
    for (int i = 0; i < 6; i++) begin
      for (int k = 0; k < 10; k++) begin
        cmp_expect(req_of(codes[k]), codes[k], 0, av[i], bv[i], 16'h0,
                   ref_rel(codes[k], av[i], bv[i]));
      end
    end
  endtask

  task automatic t_immediate;
    // R5: 16'h8000 widens to 32'hFFFF8000 even for unsigned relations
    cmp_expect("R5", 5'h02, 1, 32'h7FFFFFFF, 32'h0, 16'h8000, 1'b0);
    cmp_expect("R5", 5'h04, 1, 32'h7FFFFFFF, 32'h0, 16'h8000, 1'b1);
    cmp_expect("R5", 5'h00, 1, 32'hFFFFFFFF, 32'h0, 16'hFFFF, 1'b1);
    cmp_expect("R5", 5'h0C, 1, 32'd0, 32'h0, 16'hFFFF, 1'b0);
    cmp_expect("R5", 5'h00, 1, 32'h00007FFF, 32'h0, 16'h7FFF, 1'b1);
  endtask

  task automatic t_reg_ignores_imm;
    // R6: imm matches opa but register B is selected
    cmp_expect("R6", 5'h00, 0, 32'd3, 32'd4, 16'd3, 1'b0);
    cmp_expect("R6", 5'h00, 0, 32'd4, 32'd4, 16'hFFFF, 1'b1);
  endtask

  task automatic t_timing;
    cmp_expect("R7", 5'h00, 0, 32'd1, 32'd2, 16'h0, 1'b0);
    issue(5'h01, 0, 32'd1, 32'd2, 16'h0);
    check("R7", flag_q, 1'b1);
    check("R7", flag_we, 1'b1);
    @(negedge clk);
    check("R7", flag_we, 1'b0);
  endtask

  task automatic t_hold;
    // flag is 1; change inputs without valid so the relation would clear it
    cond_code = 5'h00; opa = 32'd1; opb = 32'd2; use_imm = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check("R8", flag_q, 1'b1);
      check("R8", flag_we, 1'b0);
    end
  endtask

  task automatic t_illegal;
    logic [4:0] bad [8] = '{5'h06, 5'h07, 5'h08, 5'h09, 5'h0E, 5'h0F, 5'h10, 5'h1F};
    for (int i = 0; i < 8; i++) begin
      cmp_expect("R9", 5'h01, 0, 32'd1, 32'd2, 16'h0, 1'b1);
      issue(bad[i], 0, 32'd5, 32'd5, 16'h0);
      check("R9", cond_illegal, 1'b1);
      check("R9", flag_we, 1'b0);
      check("R9", flag_q, 1'b1);
      @(negedge clk);
      check("R9", cond_illegal, 1'b0);
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_equality();
    t_unsigned();
    t_signed();
    t_sweep();
    t_immediate();
    t_reg_ignores_imm();
    t_timing();
    t_hold();
    t_illegal();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule